// File: doc/BRIEF.md
# Keyed Byte-Store Controller

This block fronts a 256-entry, 8-bit nonvolatile-style data store with four CPU-visible registers: an address register, a data register, a control register and an unlock key register. A CPU reads a byte by loading the address and then writing the control register with the read bit set and the region-select bit clear. The addressed byte lands in the data register at that same clock edge.

Writes are protected. Software must first set the write-enable bit. It must then write 0x55 and 0xAA to the key register on back-to-back bus writes, and the very next bus write must set the write bit in the control register. Only then does a timed program cycle begin. The cycle lasts `WR_CYCLES` clocks and works from an address and data captured at its start. When the cycle ends, hardware drops the write bit and raises a sticky completion flag. That flag can drive an interrupt line when the interrupt-enable bit is set.

The storage array lives inside the block. A down-counter stands in for the physical program time.

Top module: `keyed_nvstore_ctrl`

## Requirements
- R1: The store holds 256 bytes. Register offsets on `bus_addr` are 0 = address, 1 = data, 2 = control, 3 = key. A byte written through the keyed sequence is returned by a later read of the same address.
- R2: A control-register write with bit 0 (read) set and bit 5 (region select) clear loads the addressed byte into the data register at that clock edge. The same write with bit 5 set loads nothing. Bit 0 always reads back as 0.
- R3: The data register keeps its value until a read loads it or the CPU writes offset 1.
- R4: A write starts only after three bus writes in a row: 0x55 to the key register, then 0xAA to the key register, then a control write with bit 1 (write) set. A wrong order, or any other bus write between these steps, starts no write and leaves bit 1 clear.
- R5: Bit 1 can only be set if bit 2 (write enable) was already set before that control write.
- R6: Bit 2 changes only through a CPU control write. Hardware never clears it.
- R7: Clearing bit 2 while a write is in progress does not abort or alter that write.
- R8: A write reads back bit 1 = 1 for `WR_CYCLES` clock edges after its start edge. On the last of those edges, bit 1 clears, the byte is stored and bit 3 (done) is set. Bit 3 stays set until a control write with bit 3 = 0 clears it. Writing bit 3 = 1 leaves it unchanged.
- R9: While a write is in progress, read requests and write-bit sets are ignored. The write uses the address and data captured at its start.
- R10: `irq` is high exactly when bit 3 (done) and bit 4 (interrupt enable) are both set.
- R11: After reset, every register reads 0, `irq` is low and the unlock tracker is idle. The key register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register offset for both write and read |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the register at `bus_addr` |
| irq | output | 1 | Completion interrupt |

## Verification
Every register write takes effect at the clock edge that samples the strobe. A read request fills the data register at that same edge. The bench therefore drives each write on a falling edge and reads the result back on the next falling edge.

A program cycle keeps the write bit set through exactly `WR_CYCLES` rising edges after its start edge. The bench samples the control register once, `WR_CYCLES - 1` falling edges after starting the write, expecting the bit still set. It samples again one falling edge later, expecting the bit clear and the done flag set.

`irq` is a plain function of two flops, so it is checked in the same sample window as the flag that feeds it.

// File: rtl/kn_pkg.sv
package kn_pkg;
  // register offsets on the CPU bus
  localparam logic [1:0] RG_ADDR = 2'd0;
  localparam logic [1:0] RG_DATA = 2'd1;
  localparam logic [1:0] RG_CTRL = 2'd2;
  localparam logic [1:0] RG_KEY  = 2'd3;

  // control register bit positions
  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_WREN = 2;
  localparam int CB_DONE = 3;
  localparam int CB_IE   = 4;
  localparam int CB_SEL  = 5;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;
endpackage

// File: rtl/kn_unlock.sv
module kn_unlock #(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY1 = 8'h55,
  parameter logic [DW-1:0] KEY2 = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          armed
);
  import kn_pkg::*;

  unlock_e state_q;
  logic    key_hit;

  assign key_hit = bus_wr && (bus_addr == RG_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= UL_IDLE;
    end else if (bus_wr) begin
      if (key_hit && bus_wdata == KEY1)
        state_q <= UL_HALF;
      else if (key_hit && bus_wdata == KEY2 && state_q == UL_HALF)
        state_q <= UL_ARMED;
      else
        state_q <= UL_IDLE;
    end
  end

  assign armed = (state_q == UL_ARMED);
endmodule

// File: rtl/kn_store.sv
module kn_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/kn_wtimer.sv
module kn_wtimer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= LOAD;
    end else if (busy) begin
      if (cnt_q == '0) busy  <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign finish = busy && (cnt_q == '0);
endmodule

// File: rtl/keyed_nvstore_ctrl.sv
module keyed_nvstore_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int WR_CYCLES = 16,
  parameter logic [DW-1:0] KEY1 = 8'h55,
  parameter logic [DW-1:0] KEY2 = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  import kn_pkg::*;

  logic [AW-1:0] addr_q, lat_addr;
  logic [DW-1:0] data_q, lat_data, store_rd;
  logic          wren_q, done_q, ie_q, sel_q;
  logic          armed, busy, finish;
  logic          ctrl_wr, rd_req, wr_start;

  assign ctrl_wr  = bus_wr && (bus_addr == RG_CTRL);
  assign rd_req   = ctrl_wr && bus_wdata[CB_RD] && !bus_wdata[CB_SEL] && !busy;
  assign wr_start = ctrl_wr && bus_wdata[CB_WR] && wren_q && armed && !busy;

  kn_unlock #(.DW(DW), .KEY1(KEY1), .KEY2(KEY2)) u_unlock (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .armed(armed)
  );

  kn_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(wr_start), .busy(busy), .finish(finish)
  );

  kn_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .we(finish), .waddr(lat_addr), .wdata(lat_data),
    .raddr(addr_q), .rdata(store_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (bus_wr && bus_addr == RG_ADDR) addr_q <= bus_wdata[AW-1:0];
      if (rd_req)                             data_q <= store_rd;
      else if (bus_wr && bus_addr == RG_DATA) data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wren_q <= 1'b0;
      ie_q   <= 1'b0;
      sel_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        wren_q <= bus_wdata[CB_WREN];
        ie_q   <= bus_wdata[CB_IE];
        sel_q  <= bus_wdata[CB_SEL];
      end
      if (finish)                          done_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata[CB_DONE]) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_addr <= '0;
      lat_data <= '0;
    end else if (wr_start) begin
      lat_addr <= addr_q;
      lat_data <= data_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RG_ADDR: bus_rdata = DW'(addr_q);
      RG_DATA: bus_rdata = data_q;
      RG_CTRL: begin
        bus_rdata[CB_WR]   = busy;
        bus_rdata[CB_WREN] = wren_q;
        bus_rdata[CB_DONE] = done_q;
        bus_rdata[CB_IE]   = ie_q;
        bus_rdata[CB_SEL]  = sel_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq = done_q & ie_q;
endmodule

// File: rtl/kn_checker.sv
module kn_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          irq,
  input logic          wr_bit,
  input logic          wren,
  input logic          done,
  input logic          armed
);
  assert_wr_needs_key_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_bit) |-> $past(armed));

  assert_wr_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_bit) |-> $past(wren));

  assert_wren_sw_only_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(wren) |-> $past(bus_wr && bus_addr == 2'd2 && !bus_wdata[2]));

  assert_wren_drop_keeps_write_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(wren) && $past(wr_bit)) |-> (wr_bit || done));

  assert_end_sets_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_bit) |-> done);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(bus_wr && bus_addr == 2'd2 && !bus_wdata[3]));

  assert_irq_needs_done_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);
endmodule

bind keyed_nvstore_ctrl kn_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .wr_bit(busy), .wren(wren_q),
  .done(done_q), .armed(armed)
);

// File: tb/keyed_nvstore_ctrl_tb.sv
module keyed_nvstore_ctrl_tb;
  localparam int WRC = 16;
  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'hFF3C, 16'h5A00,
                                      16'h01FF, 16'h8069, 16'h3CC3};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;
  int         errors = 0;
  int         checks = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  keyed_nvstore_ctrl #(.WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic keyed_write(input logic [7:0] a, input logic [7:0] d);
    wr(2'd0, a); wr(2'd1, d); wr(2'd2, 8'h04);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
  endtask

  task automatic read_byte(input logic [7:0] a, output logic [7:0] v);
    wr(2'd0, a); wr(2'd2, 8'h05); rd(2'd1, v);
  endtask

  task automatic settle;
    repeat (WRC + 2) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    rd(2'd0, rv); chk("R11 addr", rv, 8'h00);
    rd(2'd1, rv); chk("R11 data", rv, 8'h00);
    rd(2'd2, rv); chk("R11 ctrl", rv, 8'h00);
    rd(2'd3, rv); chk("R11 key", rv, 8'h00);
    chk("R11 irq", {7'd0, irq}, 8'h00);

    // table walk: keyed writes with exact timing (R8), then readback (R1)
    foreach (VEC[i]) begin
      keyed_write(VEC[i][15:8], VEC[i][7:0]);
      rd(2'd2, rv); chk("R8 busy at start", rv & 8'h02, 8'h02);
      repeat (WRC - 1) @(negedge clk);
      rd(2'd2, rv); chk("R8 busy last cycle", rv & 8'h0A, 8'h02);
      @(negedge clk);
      rd(2'd2, rv); chk("R8 finish", rv & 8'h0A, 8'h08);
      rd(2'd3, rv); chk("R11 key reads zero", rv, 8'h00);
    end
    foreach (VEC[i]) begin
      read_byte(VEC[i][15:8], rv); chk("R1 readback", rv, VEC[i][7:0]);
      rd(2'd2, rv); chk("R2 read bit reads 0", rv & 8'h01, 8'h00);
    end

    // R2 select bit set: no load
    wr(2'd1, 8'h11); wr(2'd0, 8'h00); wr(2'd2, 8'h21);
    rd(2'd1, rv); chk("R2 select blocks read", rv, 8'h11);
    // R3 data held across other register writes
    read_byte(8'hFF, rv);
    wr(2'd0, 8'h80); wr(2'd3, 8'h12); wr(2'd2, 8'h00);
    rd(2'd1, rv); chk("R3 data held", rv, 8'h3C);

    // R4 wrong key order
    wr(2'd0, 8'h00); wr(2'd1, 8'h77); wr(2'd2, 8'h04);
    wr(2'd3, 8'hAA); wr(2'd3, 8'h55); wr(2'd2, 8'h06);
    rd(2'd2, rv); chk("R4 wrong order", rv & 8'h02, 8'h00);
    // R4 intervening register write
    wr(2'd3, 8'h55); wr(2'd0, 8'h00); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    rd(2'd2, rv); chk("R4 intervening addr write", rv & 8'h02, 8'h00);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd1, 8'h77); wr(2'd2, 8'h06);
    rd(2'd2, rv); chk("R4 intervening data write", rv & 8'h02, 8'h00);
    settle;
    read_byte(8'h00, rv); chk("R4 store unchanged", rv, 8'hA5);

    // R5 write enable set in the same write is too late
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h66);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    rd(2'd2, rv); chk("R5 no write without prior enable", rv & 8'h06, 8'h04);
    settle;
    read_byte(8'h00, rv); chk("R5 store unchanged", rv, 8'hA5);

    // R7 clearing enable mid-write
    keyed_write(8'h5A, 8'h42);
    wr(2'd2, 8'h00);
    rd(2'd2, rv); chk("R7 still busy after enable cleared", rv & 8'h06, 8'h02);
    settle;
    rd(2'd2, rv); chk("R7 done", rv & 8'h0A, 8'h08);
    read_byte(8'h5A, rv); chk("R7 byte stored", rv, 8'h42);

    // R9 requests during busy ignored, latched address/data used
    keyed_write(8'h80, 8'h99);
    wr(2'd0, 8'h01); wr(2'd1, 8'hE7); wr(2'd2, 8'h05);
    rd(2'd1, rv); chk("R9 read ignored while busy", rv, 8'hE7);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    settle;
    rd(2'd2, rv); chk("R6 enable kept by hardware", rv & 8'h04, 8'h04);
    read_byte(8'h80, rv); chk("R9 latched write", rv, 8'h99);
    read_byte(8'h01, rv); chk("R9 second start ignored", rv, 8'hFF);

    // R8 sticky done, R10 irq
    keyed_write(8'h3C, 8'h5E);
    settle;
    repeat (5) @(negedge clk);
    rd(2'd2, rv); chk("R8 done sticky", rv & 8'h08, 8'h08);
    chk("R10 irq low without enable", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h1C);
    rd(2'd2, rv); chk("R8 writing 1 keeps done", rv & 8'h08, 8'h08);
    chk("R10 irq high", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h14);
    rd(2'd2, rv); chk("R8 done cleared", rv & 8'h08, 8'h00);
    chk("R10 irq low after clear", {7'd0, irq}, 8'h00);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule